// File: doc/BRIEF.md
# AUX Transaction Request Framer

This block sits between a requester and an AUX channel engine of a DisplayPort source. A requester presents one transaction: a 20-bit address, a 4-bit request code, a payload length, the payload bytes and the size of its receive buffer. The framer screens the request, builds a four-byte header, streams the header and any write payload to the engine one byte at a time over a valid/ready interface, and then waits for the engine's reply: a status byte, a received byte count and the read data.

The reply is decoded into an error class, a four-bit reply code, a result count and the clipped read data. The result is held until the requester acknowledges it. Only one transaction is in flight; the block refuses new requests from acceptance until the result is consumed. Requests that are too long or carry an unknown code are answered at once with an error and put nothing on the byte stream.

Top module: `auxReqFramer`

## Requirements
- R1: Header byte 0 carries address bits 7:0, byte 1 carries address bits 15:8, and byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of header byte 3 hold the payload length minus one, or 0 for a zero length.
- R3: Bits 7:4 of header byte 3 hold 3 for a zero-length request; otherwise they hold the low four bits of the transmit count, which is 4 plus the payload length for a write and 4 for a read (a 12-byte write therefore gives 0).
- R4: A write sends the four header bytes followed by the payload bytes in index order (byte i at reqData[8i+7:8i]); a read sends only the header. txLast marks the final byte, and txData holds steady while txValid is high and txReady low.
- R5: A request with a length above 16 ends with error class 1 (too big) and sends nothing.
- R6: With bit 2 of the code cleared, codes 0, 2 and 8 are writes and codes 1 and 9 are reads; a write longer than 12 bytes ends with error class 1 and sends nothing.
- R7: Any other code ends with error class 2 (invalid) and sends nothing; the length-above-16 test is made before the code test, and the code test before the write limit.
- R8: A reply status byte of exactly 1, 2 or 3 ends the transfer with error class 3, 4 or 5 respectively, with zero reply code, count and data.
- R9: Any other status gives error class 0 and a reply code equal to status bits 7:4; a write reports its payload length as the count.
- R10: A read reports the smallest of the engine's byte count, the requester's buffer size and 16 as the count; data bytes at or above that count read as zero.
- R11: reqReady is low from the accepting edge until the edge where doneAck is taken; requests offered then, and replies offered while no reply is awaited, have no effect.
- R12: After reset reqReady is 1 and txValid and doneValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken on this edge |
| reqAddr | input | 20 | Transaction address |
| reqCode | input | 4 | Request code |
| reqLen | input | 5 | Payload length in bytes |
| reqBufSize | input | 5 | Receive buffer size of the requester |
| reqData | input | 128 | Write payload, byte i in bits 8i+7:8i |
| txValid | output | 1 | Byte offered to the engine |
| txReady | input | 1 | Engine takes the byte |
| txData | output | 8 | Outgoing byte |
| txLast | output | 1 | Final byte of the packet |
| rspValid | input | 1 | Engine reply present |
| rspStatus | input | 8 | Reply status byte |
| rspLen | input | 5 | Bytes received by the engine |
| rspData | input | 128 | Received bytes, byte i in bits 8i+7:8i |
| doneValid | output | 1 | Result present |
| doneAck | input | 1 | Requester consumes the result |
| doneErr | output | 3 | Error class 0..5 |
| doneReply | output | 4 | Reply code |
| doneCount | output | 5 | Result byte count |
| doneData | output | 128 | Clipped read data |

## Verification
A request is taken at the edge where reqValid meets reqReady; a rejected request shows doneValid one cycle later with txValid never raised, while an accepted one shows the first header byte on txData one cycle later. Each byte is taken at the edge where txReady is high, so the bench drives txReady at a falling edge and records txData at that same moment. The result appears one edge after rspValid is presented in the waiting state, and reqReady returns one edge after doneAck. The bench drives every input at the falling edge and reads every output there, exactly one rising edge after the stimulus it depends on.

// File: rtl/auxFramerPkg.sv
package auxFramerPkg;
  localparam int ADDR_W    = 20;
  localparam int CODE_W    = 4;
  localparam int HDR_BYTES = 4;
  localparam int MAX_BYTES = 16;
  localparam int MAX_WR    = 12;
  localparam int BARE_CNT  = 3;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(HDR_BYTES + MAX_BYTES + 1);
  localparam int DATA_W    = MAX_BYTES * 8;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_TOOBIG  = 3'd1,
    ERR_INVALID = 3'd2,
    ERR_TIMEOUT = 3'd3,
    ERR_FLAGS   = 3'd4,
    ERR_IO      = 3'd5
  } errT;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_BAD   = 2'd2
  } kindT;

  typedef struct packed {
    logic latchReq;
    logic loadErr;
    errT  errCode;
    logic captRsp;
  } strobeT;

  // bit 2 (middle-of-transaction flag) does not change the kind
  function automatic kindT classify(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] base;
    base = code & ~(CODE_W'(4));
    case (base)
      4'h0, 4'h2, 4'h8: classify = KIND_WRITE;
      4'h1, 4'h9:       classify = KIND_READ;
      default:          classify = KIND_BAD;
    endcase
  endfunction
endpackage

// File: rtl/auxFramerCtrl.sv
module auxFramerCtrl
  import auxFramerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              txReady,
  input  logic [IDX_W-1:0]  txTotal,
  input  logic              rspValid,
  input  logic              doneAck,
  output logic              reqReady,
  output logic              txValid,
  output logic              txLast,
  output logic [IDX_W-1:0]  txIdx,
  output logic              doneValid,
  output strobeT            strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_DONE} stateT;

  stateT state, stateNxt;
  logic  accept;
  logic  txFire;
  errT   screenErr;
  kindT  kind;

  assign accept   = reqValid && (state == ST_IDLE);
  assign reqReady = (state == ST_IDLE);
  assign txValid  = (state == ST_SEND);
  assign txLast   = txValid && (txIdx == txTotal - IDX_W'(1));
  assign txFire   = txValid && txReady;
  assign doneValid = (state == ST_DONE);

  // screening order: overall length, then code, then write length
  always_comb begin
    kind = classify(reqCode);
    if (reqLen > LEN_W'(MAX_BYTES))
      screenErr = ERR_TOOBIG;
    else if (kind == KIND_BAD)
      screenErr = ERR_INVALID;
    else if (kind == KIND_WRITE && reqLen > LEN_W'(MAX_WR))
      screenErr = ERR_TOOBIG;
    else
      screenErr = ERR_NONE;
  end

  always_comb begin
    strobe          = '0;
    strobe.errCode  = screenErr;
    strobe.latchReq = accept;
    strobe.loadErr  = accept && (screenErr != ERR_NONE);
    strobe.captRsp  = (state == ST_WAIT) && rspValid;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (accept) stateNxt = (screenErr != ERR_NONE) ? ST_DONE : ST_SEND;
      ST_SEND: if (txFire && txLast) stateNxt = ST_WAIT;
      ST_WAIT: if (rspValid) stateNxt = ST_DONE;
      ST_DONE: if (doneAck) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      txIdx <= '0;
    end else begin
      state <= stateNxt;
      if (accept)
        txIdx <= '0;
      else if (txFire)
        txIdx <= txIdx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/auxFramerData.sv
module auxFramerData
  import auxFramerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CODE_W-1:0] reqCode,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [LEN_W-1:0]  reqBufSize,
  input  logic [DATA_W-1:0] reqData,
  input  logic [IDX_W-1:0]  txIdx,
  input  logic [7:0]        rspStatus,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic [DATA_W-1:0] rspData,
  output logic [IDX_W-1:0]  txTotal,
  output logic [7:0]        txData,
  output logic [2:0]        doneErr,
  output logic [3:0]        doneReply,
  output logic [LEN_W-1:0]  doneCount,
  output logic [DATA_W-1:0] doneData
);
  logic [ADDR_W-1:0] addrQ;
  logic [CODE_W-1:0] codeQ;
  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  bufQ;
  logic [DATA_W-1:0] payQ;
  logic              isWrQ;

  errT               errQ;
  logic [3:0]        replyQ;
  logic [LEN_W-1:0]  countQ;
  logic [DATA_W-1:0] dataQ;

  logic [3:0]        lenLo;
  logic [3:0]        cntHi;
  logic [7:0]        hdrByte [HDR_BYTES];
  logic [IDX_W-1:0]  payIdx;
  logic [LEN_W-1:0]  clipCnt;
  logic [LEN_W-1:0]  clipA;
  logic [DATA_W-1:0] maskedData;
  errT               rspErr;

  assign txTotal = IDX_W'(HDR_BYTES) + (isWrQ ? IDX_W'(lenQ) : IDX_W'(0));

  // length byte: low nibble = length-1, high nibble = transmit count mod 16
  always_comb begin
    lenLo = (lenQ == '0) ? 4'd0 : 4'(lenQ - LEN_W'(1));
    if (lenQ == '0)
      cntHi = 4'(BARE_CNT);
    else if (isWrQ)
      cntHi = 4'(HDR_BYTES) + lenQ[3:0];
    else
      cntHi = 4'(HDR_BYTES);
  end

  assign hdrByte[0] = addrQ[7:0];
  assign hdrByte[1] = addrQ[15:8];
  assign hdrByte[2] = {codeQ, addrQ[19:16]};
  assign hdrByte[3] = {cntHi, lenLo};

  assign payIdx = txIdx - IDX_W'(HDR_BYTES);

  always_comb begin
    txData = 8'h00;
    if (txIdx < IDX_W'(HDR_BYTES))
      txData = hdrByte[txIdx[1:0]];
    else
      for (int i = 0; i < MAX_BYTES; i++)
        if (payIdx == IDX_W'(i)) txData = payQ[i*8 +: 8];
  end

  // reply decode
  always_comb begin
    case (rspStatus)
      8'd1:    rspErr = ERR_TIMEOUT;
      8'd2:    rspErr = ERR_FLAGS;
      8'd3:    rspErr = ERR_IO;
      default: rspErr = ERR_NONE;
    endcase
    clipA   = (rspLen < bufQ) ? rspLen : bufQ;
    clipCnt = (clipA > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : clipA;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gMask
    assign maskedData[g*8 +: 8] = (LEN_W'(g) < clipCnt) ? rspData[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      codeQ <= '0;
      lenQ  <= '0;
      bufQ  <= '0;
      payQ  <= '0;
      isWrQ <= 1'b0;
    end else if (strobe.latchReq) begin
      addrQ <= reqAddr;
      codeQ <= reqCode;
      lenQ  <= reqLen;
      bufQ  <= reqBufSize;
      payQ  <= reqData;
      isWrQ <= (classify(reqCode) == KIND_WRITE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ   <= ERR_NONE;
      replyQ <= '0;
      countQ <= '0;
      dataQ  <= '0;
    end else if (strobe.loadErr) begin
      errQ   <= strobe.errCode;
      replyQ <= '0;
      countQ <= '0;
      dataQ  <= '0;
    end else if (strobe.captRsp) begin
      errQ <= rspErr;
      if (rspErr != ERR_NONE) begin
        replyQ <= '0;
        countQ <= '0;
        dataQ  <= '0;
      end else begin
        replyQ <= rspStatus[7:4];
        countQ <= isWrQ ? lenQ : clipCnt;
        dataQ  <= isWrQ ? '0 : maskedData;
      end
    end
  end

  assign doneErr   = errQ;
  assign doneReply = replyQ;
  assign doneCount = countQ;
  assign doneData  = dataQ;
endmodule

// File: rtl/auxReqFramer.sv
module auxReqFramer
  import auxFramerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CODE_W-1:0] reqCode,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [LEN_W-1:0]  reqBufSize,
  input  logic [DATA_W-1:0] reqData,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              rspValid,
  input  logic [7:0]        rspStatus,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic [DATA_W-1:0] rspData,
  output logic              doneValid,
  input  logic              doneAck,
  output logic [2:0]        doneErr,
  output logic [3:0]        doneReply,
  output logic [LEN_W-1:0]  doneCount,
  output logic [DATA_W-1:0] doneData
);
  strobeT           strobe;
  logic [IDX_W-1:0] txIdx;
  logic [IDX_W-1:0] txTotal;

  auxFramerCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCode   (reqCode),
    .reqLen    (reqLen),
    .txReady   (txReady),
    .txTotal   (txTotal),
    .rspValid  (rspValid),
    .doneAck   (doneAck),
    .reqReady  (reqReady),
    .txValid   (txValid),
    .txLast    (txLast),
    .txIdx     (txIdx),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  auxFramerData uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqCode    (reqCode),
    .reqLen     (reqLen),
    .reqBufSize (reqBufSize),
    .reqData    (reqData),
    .txIdx      (txIdx),
    .rspStatus  (rspStatus),
    .rspLen     (rspLen),
    .rspData    (rspData),
    .txTotal    (txTotal),
    .txData     (txData),
    .doneErr    (doneErr),
    .doneReply  (doneReply),
    .doneCount  (doneCount),
    .doneData   (doneData)
  );
endmodule

// File: rtl/auxFramerChk.sv
module auxFramerChk
  import auxFramerPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [CODE_W-1:0] reqCode,
  input logic [LEN_W-1:0]  reqLen,
  input logic              txValid,
  input logic              txReady,
  input logic [7:0]        txData,
  input logic              txLast,
  input logic              doneValid,
  input logic              doneAck,
  input logic [2:0]        doneErr,
  input logic [3:0]        doneReply,
  input logic [LEN_W-1:0]  doneCount
);
  // R4: byte held under backpressure
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  // R11: idle, sending and result phases are exclusive
  p_busy_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({reqReady, txValid, doneValid}) <= 1);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneAck |=> doneValid && $stable(doneErr) && $stable(doneCount) && $stable(doneReply));

  // R5: oversize request answered next cycle without transmission
  p_oversize_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqLen > LEN_W'(MAX_BYTES) |=> doneValid && !txValid && doneErr == 3'd1);

  // R7: unknown code answered next cycle without transmission
  p_bad_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqLen <= LEN_W'(MAX_BYTES) && classify(reqCode) == KIND_BAD
    |=> doneValid && !txValid && doneErr == 3'd2);

  // R8: error results carry no count or reply
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneErr != 3'd0 |-> doneCount == '0 && doneReply == '0);

  // R10: count never above the payload maximum
  p_count_max_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneCount <= LEN_W'(MAX_BYTES));
endmodule

bind auxReqFramer auxFramerChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqCode   (reqCode),
  .reqLen    (reqLen),
  .txValid   (txValid),
  .txReady   (txReady),
  .txData    (txData),
  .txLast    (txLast),
  .doneValid (doneValid),
  .doneAck   (doneAck),
  .doneErr   (doneErr),
  .doneReply (doneReply),
  .doneCount (doneCount)
);

// File: tb/sim_auxReqFramer.sv
module sim_auxReqFramer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [19:0]  reqAddr = '0;
  logic [3:0]   reqCode = '0;
  logic [4:0]   reqLen = '0;
  logic [4:0]   reqBufSize = '0;
  logic [127:0] reqData = '0;
  logic         txValid;
  logic         txReady = 1'b0;
  logic [7:0]   txData;
  logic         txLast;
  logic         rspValid = 1'b0;
  logic [7:0]   rspStatus = '0;
  logic [4:0]   rspLen = '0;
  logic [127:0] rspData = '0;
  logic         doneValid;
  logic         doneAck = 1'b0;
  logic [2:0]   doneErr;
  logic [3:0]   doneReply;
  logic [4:0]   doneCount;
  logic [127:0] doneData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxReqFramer u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // 0 write, 1 read, 2 bad
  function automatic int kindOf(input logic [3:0] c);
    logic [3:0] b;
    b = c & 4'hB;
    if (b == 4'h0 || b == 4'h2 || b == 4'h8) return 0;
    if (b == 4'h1 || b == 4'h9) return 1;
    return 2;
  endfunction

  function automatic int screen(input logic [3:0] c, input int len);
    if (len > 16) return 1;
    if (kindOf(c) == 2) return 2;
    if (kindOf(c) == 0 && len > 12) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] expByte(input int k, input logic [19:0] a,
      input logic [3:0] c, input int len, input logic [127:0] pay);
    logic [3:0] hi, lo;
    case (k)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      3: begin
        lo = (len == 0) ? 4'd0 : 4'(len - 1);
        hi = (len == 0) ? 4'd3 : (kindOf(c) == 0 ? 4'(4 + len) : 4'd4);
        return {hi, lo};
      end
      default: return pay[(k-4)*8 +: 8];
    endcase
  endfunction

  task automatic runTxn(input logic [19:0] a, input logic [3:0] c, input int len,
                        input int bufSz, input logic [7:0] st, input int rlen);
    logic [127:0] pay, rd, expData;
    int pre, nexp, got, expErr, expCnt, clip;
    bit fin;
    logic [7:0] bytes [24];
    pay = {$urandom, $urandom, $urandom, $urandom};
    rd  = {$urandom, $urandom, $urandom, $urandom};
    pre = screen(c, len);
    @(negedge clk);
    chk(reqReady == 1'b1, "R11", "ready before request", 128'(reqReady), 128'd1);
    reqValid = 1'b1; reqAddr = a; reqCode = c; reqLen = 5'(len);
    reqBufSize = 5'(bufSz); reqData = pay;
    @(negedge clk);
    // junk offered while busy must be ignored
    reqAddr = 20'(~a); reqCode = 4'($urandom); reqLen = 5'($urandom); reqData = ~pay;
    chk(reqReady == 1'b0, "R11", "ready while busy", 128'(reqReady), 128'd0);
    if (pre != 0) begin
      string rq;
      rq = (len > 16) ? "R5" : (pre == 2 ? "R7" : "R6");
      chk(txValid == 1'b0 && doneValid == 1'b1, rq, "no tx, result", 128'({txValid, doneValid}), 128'b01);
      chk(doneErr == 3'(pre), rq, "screen error class", 128'(doneErr), 128'(pre));
    end else begin
      nexp = 4 + ((kindOf(c) == 0) ? len : 0);
      got = 0; fin = 1'b0;
      while (!fin) begin
        txReady = 1'($urandom);
        rspValid = 1'($urandom); rspStatus = 8'd1; // ignored while sending
        if (txValid && txReady) begin
          if (got < 24) bytes[got] = txData;
          got++;
          if (txLast) fin = 1'b1;
        end
        @(negedge clk);
      end
      txReady = 1'b0;
      chk(got == nexp, "R4", "byte count", 128'(got), 128'(nexp));
      for (int k = 0; k < nexp && k < got; k++) begin
        string rq;
        rq = (k < 3) ? "R1" : (k == 3 ? "R3" : "R4");
        if (k == 3)
          chk(bytes[3][3:0] == expByte(3, a, c, len, pay)[3:0], "R2", "length nibble",
              128'(bytes[3][3:0]), 128'(expByte(3, a, c, len, pay)[3:0]));
        chk(bytes[k] == expByte(k, a, c, len, pay), rq, $sformatf("tx byte %0d", k),
            128'(bytes[k]), 128'(expByte(k, a, c, len, pay)));
      end
      rspValid = 1'b1; rspStatus = st; rspLen = 5'(rlen); rspData = rd;
      @(negedge clk);
      rspValid = 1'b0;
      if (st == 8'd1) expErr = 3; else if (st == 8'd2) expErr = 4;
      else if (st == 8'd3) expErr = 5; else expErr = 0;
      clip = (rlen < bufSz) ? rlen : bufSz;
      if (clip > 16) clip = 16;
      expData = '0;
      if (expErr != 0) expCnt = 0;
      else if (kindOf(c) == 0) expCnt = len;
      else begin
        expCnt = clip;
        for (int i = 0; i < 16; i++) if (i < clip) expData[i*8 +: 8] = rd[i*8 +: 8];
      end
      chk(doneValid == 1'b1, "R9", "result present", 128'(doneValid), 128'd1);
      chk(doneErr == 3'(expErr), "R8", "reply error class", 128'(doneErr), 128'(expErr));
      chk(doneReply == ((expErr == 0) ? st[7:4] : 4'd0), "R9", "reply code",
          128'(doneReply), 128'((expErr == 0) ? st[7:4] : 4'd0));
      chk(doneCount == 5'(expCnt), "R10", "result count", 128'(doneCount), 128'(expCnt));
      chk(doneData == expData, "R10", "clipped data", doneData, expData);
    end
    reqValid = 1'b0;
    if ($urandom % 2) @(negedge clk);
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
    chk(reqReady == 1'b1 && doneValid == 1'b0, "R11", "idle after ack",
        128'({reqReady, doneValid}), 128'b10);
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] stSet [7];
    void'($urandom(32'd20240611));
    stSet[0] = 8'h00; stSet[1] = 8'h10; stSet[2] = 8'h20; stSet[3] = 8'h01;
    stSet[4] = 8'h02; stSet[5] = 8'h03; stSet[6] = 8'h80;
    @(negedge clk);
    chk(reqReady == 1'b1 && txValid == 1'b0 && doneValid == 1'b0, "R12", "reset state",
        128'({reqReady, txValid, doneValid}), 128'b100);
    rstN = 1'b1;
    // reply while idle is ignored
    rspValid = 1'b1; rspStatus = 8'h10;
    @(negedge clk);
    rspValid = 1'b0;
    chk(doneValid == 1'b0, "R11", "idle reply ignored", 128'(doneValid), 128'd0);
    // directed corners
    runTxn(20'hABCDE, 4'h8, 12, 16, 8'h00, 0);  // R3 wrap to 0
    runTxn(20'h12345, 4'h9, 0, 16, 8'h00, 0);   // bare read, R3 value 3
    runTxn(20'h00001, 4'h0, 0, 0, 8'h10, 0);    // bare write
    runTxn(20'hFFFFF, 4'h0, 13, 16, 8'h00, 0);  // R6 write too big
    runTxn(20'h0F0F0, 4'h1, 13, 16, 8'h00, 13); // read of 13 accepted
    runTxn(20'h33333, 4'h9, 17, 16, 8'h00, 0);  // R5
    runTxn(20'h44444, 4'hA, 14, 16, 8'h00, 0);  // R7 before write limit
    runTxn(20'h55555, 4'hC, 2, 16, 8'h20, 0);   // write with MOT bit
    runTxn(20'h66666, 4'h9, 16, 5, 8'h00, 16);  // R10 clip to buffer
    runTxn(20'h77777, 4'h5, 8, 16, 8'h00, 20);  // R10 clip to 16
    runTxn(20'h88888, 4'h9, 4, 16, 8'h01, 4);   // R8 timeout
    runTxn(20'h99999, 4'h2, 3, 16, 8'h02, 0);   // R8 flags
    runTxn(20'hAAAAA, 4'h1, 3, 16, 8'h03, 3);   // R8 error
    for (int n = 0; n < 60; n++)
      runTxn(20'($urandom), 4'($urandom), int'($urandom % 20), int'($urandom % 20),
             stSet[$urandom % 7], int'($urandom % 20));
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule